// File: doc/BRIEF.md
# Power-Up Fingerprint Enrollment and Nearest-Match Identifier

This block turns noisy power-up readouts of a fixed group of memory bits into a stable reference pattern and later decides which enrolled device an unknown readout came from. During enrollment it collects an odd number of readouts. Each reference bit is the majority of that bit over those readouts, which removes most of the noise from cells that do not settle the same way every time. The resulting pattern is stored in an internal table at an index chosen by the caller, and that table entry is marked valid.

During identification the block takes one fresh readout. It walks the table one entry per clock and measures the Hamming distance between the readout and every valid entry. It then reports the index of the closest entry together with that distance. The match is fuzzy by design. The surrounding logic compares the reported distance with its own threshold to accept or reject the match. Readouts arrive as parallel words qualified by a valid strobe. Commands are single-cycle start pulses that the block accepts only while it is idle.

Top module: `fpMatcher`

## Requirements
- R1: After reset, `busy`, `enrollDone` and `idDone` are low and every table entry is invalid.
- R2: An enrolled reference bit is 1 when more than half of the NUM_READS readouts (default 3) had that bit at 1, and 0 otherwise.
- R3: During enrollment, `busy` is high from the cycle after the accepted `enrollStart` until the last readout is accepted. `enrollDone` is high for exactly one cycle, the cycle after the edge that accepts the NUM_READS-th readout.
- R4: The per-bit vote counts are cleared at every enrollment start, so readouts of an earlier enrollment never influence a later one.
- R5: After an accepted `identStart`, the first `sampleValid` word is captured. `idDone` goes high for one cycle on the DEPTH-th rising edge after the capture edge, and at that point `busy` is low.
- R6: When `idDone` is high, `idIndex` is the index of the valid entry with the smallest Hamming distance (popcount of XOR) to the sample, `idDist` is that distance, and `idFound` is 1.
- R7: When several valid entries share the smallest distance, the lowest index is reported.
- R8: Invalid entries take no part in the search. With no valid entry, `idFound` is 0 and `idIndex` and `idDist` are both 0.
- R9: `enrollStart` and `identStart` are ignored while `busy` is high, and `sampleValid` is ignored while the block is idle.
- R10: Enrolling at an index that already holds a reference replaces that reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enrollStart | input | 1 | Start enrollment pulse |
| enrollIdx | input | $clog2(DEPTH) | Table index written by the enrollment |
| identStart | input | 1 | Start identification pulse |
| sampleValid | input | 1 | Readout word qualifier |
| sampleWord | input | WIDTH | Readout word |
| busy | output | 1 | Enrollment or identification in progress |
| enrollDone | output | 1 | One-cycle pulse when the reference has been written |
| idDone | output | 1 | One-cycle pulse when the table scan has finished |
| idFound | output | 1 | At least one valid entry was compared |
| idIndex | output | $clog2(DEPTH) | Index of the nearest entry |
| idDist | output | $clog2(WIDTH+1) | Hamming distance to the nearest entry |

## Verification
The bench enrolls readout triples in which each readout differs from the others in scattered bits. A design that averaged wrongly or simply kept the last word would store a pattern that no longer matches at distance zero. Two entries placed at equal distance from a probe check the tie rule; a design that uses a non-strict comparison would report the higher index. An all-ones enrollment followed directly by an all-zeros one exposes vote counts that are not cleared, because stale ones would survive the majority. Start and readout pulses that arrive while the block is busy or idle check that stray strobes neither restart the block nor add a vote. An empty-table search checks that invalid entries are skipped and that the result reads as not found.

// File: rtl/fpPkg.sv
package fpPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ENROLL,
    ST_WAIT,
    ST_SCAN
  } fpState_t;

  typedef struct packed {
    logic clearVotes;
    logic accumVote;
    logic writeEntry;
    logic captureSample;
    logic scanClear;
    logic scanStep;
  } fpStrobe_t;

endpackage

// File: rtl/fpCtrl.sv
module fpCtrl
  import fpPkg::*;
#(
  parameter int NUM_READS = 3,
  parameter int DEPTH     = 16,
  parameter int IDXW      = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enrollStart,
  input  logic [IDXW-1:0] enrollIdx,
  input  logic            identStart,
  input  logic            sampleValid,
  output fpStrobe_t       strobe,
  output logic [IDXW-1:0] entryIdx,
  output logic            busy,
  output logic            enrollDone,
  output logic            idDone
);

  localparam int CNTW = $clog2(NUM_READS + 1);
  localparam logic [CNTW-1:0] LAST_READ = CNTW'(NUM_READS - 1);
  localparam logic [IDXW-1:0] LAST_ENTRY = IDXW'(DEPTH - 1);

  fpState_t state, stateNext;
  logic [CNTW-1:0] readCnt;
  logic [IDXW-1:0] wrIdx;
  logic [IDXW-1:0] scanIdx;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (enrollStart) begin
          strobe.clearVotes = 1'b1;
          stateNext = ST_ENROLL;
        end else if (identStart) begin
          stateNext = ST_WAIT;
        end
      end
      ST_ENROLL: begin
        if (sampleValid) begin
          strobe.accumVote = 1'b1;
          if (readCnt == LAST_READ) begin
            strobe.writeEntry = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_WAIT: begin
        if (sampleValid) begin
          strobe.captureSample = 1'b1;
          strobe.scanClear     = 1'b1;
          stateNext = ST_SCAN;
        end
      end
      ST_SCAN: begin
        strobe.scanStep = 1'b1;
        if (scanIdx == LAST_ENTRY) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      readCnt    <= '0;
      wrIdx      <= '0;
      scanIdx    <= '0;
      enrollDone <= 1'b0;
      idDone     <= 1'b0;
    end else begin
      state      <= stateNext;
      enrollDone <= strobe.writeEntry;
      idDone     <= strobe.scanStep && (scanIdx == LAST_ENTRY);
      if (strobe.clearVotes) begin
        readCnt <= '0;
        wrIdx   <= enrollIdx;
      end else if (strobe.accumVote) begin
        readCnt <= readCnt + 1'b1;
      end
      if (strobe.scanClear) scanIdx <= '0;
      else if (strobe.scanStep) scanIdx <= scanIdx + 1'b1;
    end
  end

  assign entryIdx = (state == ST_SCAN) ? scanIdx : wrIdx;
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/fpDatapath.sv
module fpDatapath
  import fpPkg::*;
#(
  parameter int WIDTH     = 64,
  parameter int NUM_READS = 3,
  parameter int DEPTH     = 16,
  parameter int IDXW      = 4,
  parameter int DISTW     = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  fpStrobe_t        strobe,
  input  logic [IDXW-1:0]  entryIdx,
  input  logic [WIDTH-1:0] sampleWord,
  output logic             bestHit,
  output logic [IDXW-1:0]  bestIdx,
  output logic [DISTW-1:0] bestDist
);

  localparam int CNTW = $clog2(NUM_READS + 1);
  localparam logic [CNTW-1:0] HALF = CNTW'(NUM_READS / 2);

  logic [WIDTH-1:0] majority;
  logic [WIDTH-1:0] refTable [DEPTH];
  logic [DEPTH-1:0] entryValid;
  logic [WIDTH-1:0] sampleReg;
  logic [DISTW-1:0] curDist;

  function automatic logic [DISTW-1:0] popCount(input logic [WIDTH-1:0] v);
    logic [DISTW-1:0] acc;
    acc = '0;
    for (int i = 0; i < WIDTH; i++) acc = acc + DISTW'(v[i]);
    return acc;
  endfunction

  // per-bit vote counters; the majority includes the readout being accepted
  for (genvar g = 0; g < WIDTH; g++) begin : g_vote
    logic [CNTW-1:0] voteCnt;
    logic [CNTW-1:0] voteNext;
    assign voteNext    = voteCnt + CNTW'(sampleWord[g]);
    assign majority[g] = (voteNext > HALF);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) voteCnt <= '0;
      else if (strobe.clearVotes) voteCnt <= '0;
      else if (strobe.accumVote) voteCnt <= voteNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeEntry) refTable[entryIdx] <= majority;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryValid <= '0;
      sampleReg  <= '0;
    end else begin
      if (strobe.writeEntry) entryValid[entryIdx] <= 1'b1;
      if (strobe.captureSample) sampleReg <= sampleWord;
    end
  end

  assign curDist = popCount(sampleReg ^ refTable[entryIdx]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestHit  <= 1'b0;
      bestIdx  <= '0;
      bestDist <= '0;
    end else if (strobe.scanClear) begin
      bestHit  <= 1'b0;
      bestIdx  <= '0;
      bestDist <= '0;
    end else if (strobe.scanStep && entryValid[entryIdx] &&
                 (!bestHit || (curDist < bestDist))) begin
      bestHit  <= 1'b1;
      bestIdx  <= entryIdx;
      bestDist <= curDist;
    end
  end

endmodule

// File: rtl/fpMatcher.sv
module fpMatcher
  import fpPkg::*;
#(
  parameter int WIDTH     = 64,
  parameter int DEPTH     = 16,
  parameter int NUM_READS = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         enrollStart,
  input  logic [$clog2(DEPTH)-1:0]     enrollIdx,
  input  logic                         identStart,
  input  logic                         sampleValid,
  input  logic [WIDTH-1:0]             sampleWord,
  output logic                         busy,
  output logic                         enrollDone,
  output logic                         idDone,
  output logic                         idFound,
  output logic [$clog2(DEPTH)-1:0]     idIndex,
  output logic [$clog2(WIDTH+1)-1:0]   idDist
);

  localparam int IDXW  = $clog2(DEPTH);
  localparam int DISTW = $clog2(WIDTH + 1);

  fpStrobe_t       strobe;
  logic [IDXW-1:0] entryIdx;

  fpCtrl #(
    .NUM_READS(NUM_READS),
    .DEPTH    (DEPTH),
    .IDXW     (IDXW)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enrollStart(enrollStart),
    .enrollIdx  (enrollIdx),
    .identStart (identStart),
    .sampleValid(sampleValid),
    .strobe     (strobe),
    .entryIdx   (entryIdx),
    .busy       (busy),
    .enrollDone (enrollDone),
    .idDone     (idDone)
  );

  fpDatapath #(
    .WIDTH    (WIDTH),
    .NUM_READS(NUM_READS),
    .DEPTH    (DEPTH),
    .IDXW     (IDXW),
    .DISTW    (DISTW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .entryIdx  (entryIdx),
    .sampleWord(sampleWord),
    .bestHit   (idFound),
    .bestIdx   (idIndex),
    .bestDist  (idDist)
  );

endmodule

// File: rtl/fpMatcherChk.sv
module fpMatcherChk #(
  parameter int WIDTH = 64,
  parameter int IDXW  = 4,
  parameter int DISTW = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             enrollStart,
  input logic             identStart,
  input logic             sampleValid,
  input logic             busy,
  input logic             enrollDone,
  input logic             idDone,
  input logic             idFound,
  input logic [IDXW-1:0]  idIndex,
  input logic [DISTW-1:0] idDist
);

  AST_ENROLL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    enrollDone |=> !enrollDone); // R3

  AST_ENROLL_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    enrollDone |-> ($past(sampleValid) && $past(busy) && !busy)); // R3

  AST_ID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    idDone |=> !idDone); // R5

  AST_ID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    idDone |-> ($past(busy) && !busy)); // R5

  AST_DIST_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (idDone && idFound) |-> (idDist <= DISTW'(WIDTH))); // R6

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (idDone && !idFound) |-> (idIndex == '0 && idDist == '0)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !enrollStart && !identStart) |=> !busy); // R9

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && !idDone) |-> ($stable(idIndex) && $stable(idDist))); // R6

endmodule

bind fpMatcher fpMatcherChk #(
  .WIDTH(WIDTH),
  .IDXW ($clog2(DEPTH)),
  .DISTW($clog2(WIDTH + 1))
) u_fpMatcherChk (
  .clk        (clk),
  .rstN       (rstN),
  .enrollStart(enrollStart),
  .identStart (identStart),
  .sampleValid(sampleValid),
  .busy       (busy),
  .enrollDone (enrollDone),
  .idDone     (idDone),
  .idFound    (idFound),
  .idIndex    (idIndex),
  .idDist     (idDist)
);

// File: tb/test_fpMatcher.sv
`timescale 1ns/1ps
module test_fpMatcher;

  localparam int WIDTH = 64;
  localparam int DEPTH = 16;
  localparam int IDXW  = 4;
  localparam int DISTW = 7;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enrollStart = 1'b0;
  logic [IDXW-1:0]  enrollIdx = '0;
  logic             identStart = 1'b0;
  logic             sampleValid = 1'b0;
  logic [WIDTH-1:0] sampleWord = '0;
  logic             busy, enrollDone, idDone, idFound;
  logic [IDXW-1:0]  idIndex;
  logic [DISTW-1:0] idDist;

  int checks = 0;
  int errors = 0;

  logic [WIDTH-1:0] mRef [DEPTH];
  logic             mValid [DEPTH];

  always #2.5 clk = ~clk;

  fpMatcher #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NUM_READS(3)) i_fpMatcher (
    .clk(clk), .rstN(rstN), .enrollStart(enrollStart), .enrollIdx(enrollIdx),
    .identStart(identStart), .sampleValid(sampleValid), .sampleWord(sampleWord),
    .busy(busy), .enrollDone(enrollDone), .idDone(idDone), .idFound(idFound),
    .idIndex(idIndex), .idDist(idDist)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // enroll three readouts at idx; optionally pulse identStart mid-enrollment (R9)
  task automatic runEnroll(input logic [IDXW-1:0] idx, input logic [63:0] w0,
                           input logic [63:0] w1, input logic [63:0] w2,
                           input bit pokeIdent);
    logic [63:0] words [3];
    words[0] = w0; words[1] = w1; words[2] = w2;
    @(negedge clk);
    enrollStart = 1'b1; enrollIdx = idx;
    @(negedge clk);
    enrollStart = 1'b0;
    check("R3 busy during enrollment", busy, 1);
    for (int k = 0; k < 3; k++) begin
      sampleValid = 1'b1; sampleWord = words[k];
      identStart = pokeIdent && (k == 1);
      @(negedge clk);
      identStart = 1'b0;
      if (k < 2) begin
        if (enrollDone !== 1'b0) check("R3 early enrollDone", enrollDone, 0);
        if (busy !== 1'b1) check("R3/R9 busy mid-enrollment", busy, 1);
      end
    end
    sampleValid = 1'b0;
    check("R3 enrollDone after last readout", enrollDone, 1);
    check("R3 idle after enrollment", busy, 0);
    @(negedge clk);
    check("R3 enrollDone single cycle", enrollDone, 0);
    mRef[idx]   = (w0 & w1) | (w0 & w2) | (w1 & w2);
    mValid[idx] = 1'b1;
  endtask

  // identify sample; optionally pulse enrollStart during the scan (R9)
  task automatic runIdentify(input logic [63:0] smp, input string tag, input bit pokeEnroll);
    logic        eFound;
    logic [3:0]  eIdx;
    logic [6:0]  eDist;
    eFound = 1'b0; eIdx = '0; eDist = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (mValid[i]) begin
        int d;
        d = $countones(smp ^ mRef[i]);
        if (!eFound || d < int'(eDist)) begin
          eFound = 1'b1; eIdx = 4'(i); eDist = 7'(d);
        end
      end
    end
    @(negedge clk);
    identStart = 1'b1;
    @(negedge clk);
    identStart = 1'b0; sampleValid = 1'b1; sampleWord = smp;
    @(negedge clk);
    sampleValid = 1'b0; sampleWord = ~smp;
    enrollStart = pokeEnroll; enrollIdx = 4'd0;
    @(negedge clk);
    enrollStart = 1'b0;
    repeat (DEPTH - 2) @(negedge clk);
    check({tag, " R5 idDone not early"}, idDone, 0);
    @(negedge clk);
    check({tag, " R5 idDone on time"}, idDone, 1);
    check({tag, " R5/R9 idle at done"}, busy, 0);
    check({tag, " R6/R8 found"}, idFound, eFound);
    check({tag, " R6/R7 index"}, idIndex, eIdx);
    check({tag, " R6 distance"}, idDist, eDist);
    @(negedge clk);
    check({tag, " R5 idDone single cycle"}, idDone, 0);
  endtask

  task automatic testReset();
    check("R1 busy after reset", busy, 0);
    check("R1 enrollDone after reset", enrollDone, 0);
    check("R1 idDone after reset", idDone, 0);
    runIdentify(64'h1234_5678_9ABC_DEF0, "R1 R8 empty", 1'b0);
    check("R8 empty index zero", idIndex, 0);
    check("R8 empty distance zero", idDist, 0);
  endtask

  task automatic testMajority();
    logic [63:0] a, x, y, z;
    a = 64'hA5C3_19F0_7E42_D6B8;
    runEnroll(4'd3, a ^ 64'h0000_00F0_0000_0011, a ^ 64'h0100_0000_0F00_0000, a, 1'b0);
    runIdentify(a, "R2 noisy triple", 1'b0);
    check("R2 exact match index", idIndex, 3);
    check("R2 exact match distance", idDist, 0);
    runIdentify(a ^ 64'h8000_0000_0000_0005, "R6 three flips", 1'b0);
    check("R6 three flips distance", idDist, 3);
    x = 64'h0F0F_3C3C_AAAA_5555; y = 64'h00FF_33CC_A5A5_F00F; z = 64'hF00F_0F3C_5A5A_0FF0;
    runEnroll(4'd5, x, y, z, 1'b0);
    runIdentify((x & y) | (x & z) | (y & z), "R2 scattered triple", 1'b0);
    check("R2 scattered triple index", idIndex, 5);
    check("R2 scattered triple distance", idDist, 0);
  endtask

  task automatic testTie();
    logic [63:0] s;
    s = 64'h6C1E_93B7_04DA_2F58;
    runEnroll(4'd7, s ^ 64'h2, s ^ 64'h2, s ^ 64'h2, 1'b0);
    runEnroll(4'd2, s ^ 64'h1, s ^ 64'h1, s ^ 64'h1, 1'b0);
    runIdentify(s, "R7 tie", 1'b0);
    check("R7 tie picks lower index", idIndex, 2);
    check("R7 tie distance", idDist, 1);
  endtask

  task automatic testClear();
    runEnroll(4'd10, '1, '1, '1, 1'b0);
    runEnroll(4'd11, '0, '0, '0, 1'b0);
    runIdentify(64'h0, "R4 counters cleared", 1'b0);
    check("R4 zero pattern index", idIndex, 11);
    check("R4 zero pattern distance", idDist, 0);
  endtask

  task automatic testOverwrite();
    logic [63:0] a;
    a = 64'hA5C3_19F0_7E42_D6B8;
    runEnroll(4'd3, ~a, ~a, ~a, 1'b0);
    runIdentify(~a, "R10 overwrite", 1'b0);
    check("R10 new pattern index", idIndex, 3);
    check("R10 new pattern distance", idDist, 0);
  endtask

  task automatic testIgnore();
    logic [63:0] q;
    q = 64'h55AA_0FF0_C33C_9669;
    @(negedge clk);
    sampleValid = 1'b1; sampleWord = '1;
    repeat (2) @(negedge clk);
    sampleValid = 1'b0;
    check("R9 stray readout keeps idle", busy, 0);
    runEnroll(4'd14, q, q ^ 64'hFFFF, q, 1'b1);
    runIdentify(q, "R9 ignored strobes", 1'b1);
    check("R9 index after ignored strobes", idIndex, 14);
    check("R9 distance after ignored strobes", idDist, 0);
    @(negedge clk);
    check("R9 start during scan ignored", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mRef[i] = '0; mValid[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMajority();
    testTie();
    testClear();
    testOverwrite();
    testIgnore();
    finishRun();
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule